// File: doc/BRIEF.md
# Call-Progress Tone Classifier

This block classifies the frequency of a hard-limited, one-bit audio signal into one of thirteen call-progress tone bands. It counts reference clock cycles across a fixed number of input periods. It then matches that count against per-band minimum and maximum cycle counts, which are computed at elaboration from the clock rate. A window that matches no band, or a silent input, gives a no-tone result.

Each raw result must stay unchanged for a qualification time, counted in milliseconds, before it is reported. A new tone needs a different hold time than a return to silence. The reported code changes only together with a one-cycle strobe. After reset a boot code is held until a programmable start-up delay expires.

Top module: `cpt_classifier`

## Requirements
- R1: During reset and until STARTUP_MS milliseconds after reset release, `tone_code` is 0xE and `result_valid` stays low.
- R2: With a silent input, the no-tone code 0xF is reported with a strobe when the start-up delay expires.
- R3: A steady tone maps to a code in ascending frequency order: 375→0x0, 400→0x1, 425→0x2, 450→0x3, 475→0x4, 500→0x5, 550→0x6, 600→0x7, 950→0x8, 1300→0x9, 1400→0xA, 1800→0xB, 2100→0xC Hz. Codes 0xD and 0xE are never reported after start-up.
- R4: A tone whose measured count lies in the gap between bands (for example 1330 Hz, between the 1273–1325 Hz and 1350–1455 Hz bands) is treated as no-tone, so no strobe occurs while 0xF is already reported.
- R5: A tone code is reported after the first window of N_EDGES periods plus ONSET_MS of stable raw result, with a resolution of one millisecond.
- R6: After the input stops toggling, the raw result becomes no-tone once TIMEOUT_CYC cycles pass without a rising edge. 0xF is then reported LOSS_MS later.
- R7: `result_valid` is a single-cycle pulse, and `tone_code` changes only in a cycle where `result_valid` is high.
- R8: A raw result that lasts less than its qualification time is never reported. A short tone burst followed by silence leaves the output at 0xF with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_in | input | 1 | Hard-limited audio input, asynchronous |
| tone_code | output | 4 | Last reported band code, 0xF no tone, 0xE before start-up |
| result_valid | output | 1 | One-cycle strobe when `tone_code` takes a new value |

## Verification
A period counter or edge counter that is off by even one shifts every band's count. A bad count shows up as a wrong code or a missing strobe one qualification time after the first window completes. A broken gap timer shows up at the ports one loss interval after a tone ends: either no 0xF strobe arrives, or it arrives outside its window. A qualifier that skips or restarts its age early shows up as a strobe earlier than the onset window, or as a burst that gets reported. The bench times every strobe against windows derived from the period count and the millisecond delays, and it checks on every clock that the code holds between strobes.

// File: rtl/cptd_pkg.sv
package cptd_pkg;
   typedef logic [3:0] code_t;

   localparam int    NUM_BANDS = 13;
   localparam code_t CODE_NONE = 4'hF;
   localparam code_t CODE_BOOT = 4'hE;
   localparam code_t CODE_RSVD = 4'hD;

   // Lower band edge in Hz per code; codes rise with frequency.
   function automatic int band_lo_hz(input int idx);
      case (idx)
         0:  return 368;
         1:  return 392;
         2:  return 417;
         3:  return 441;
         4:  return 466;
         5:  return 490;
         6:  return 539;
         7:  return 588;
         8:  return 931;
         9:  return 1273;
         10: return 1350;
         11: return 1750;
         12: return 2062;
         default: return 1;
      endcase
   endfunction

   // Upper band edge in Hz per code.
   function automatic int band_hi_hz(input int idx);
      case (idx)
         0:  return 382;
         1:  return 408;
         2:  return 433;
         3:  return 459;
         4:  return 484;
         5:  return 510;
         6:  return 561;
         7:  return 612;
         8:  return 969;
         9:  return 1325;
         10: return 1455;
         11: return 1855;
         12: return 2140;
         default: return 1;
      endcase
   endfunction
endpackage

// File: rtl/cptd_edge.sv
module cptd_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic s;
   logic s_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= din;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) s_d <= 1'b0;
      else        s_d <= s;
   end

   assign rise = s & ~s_d;
endmodule

// File: rtl/cptd_period.sv
module cptd_period #(
   parameter int N_EDGES     = 8,
   parameter int TIMEOUT_CYC = 11931,
   parameter int CNT_W       = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             meas_valid,
   output logic [CNT_W-1:0] meas_cnt,
   output logic             meas_none
);
   localparam int EDGE_W  = $clog2(N_EDGES);
   localparam int GAP_W   = $clog2(TIMEOUT_CYC);
   localparam int CNT_MAX = N_EDGES * TIMEOUT_CYC;

   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic [EDGE_W-1:0] edges;
   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         cnt        <= '0;
         edges      <= '0;
         gap        <= '0;
         meas_valid <= 1'b0;
         meas_none  <= 1'b0;
         meas_cnt   <= '0;
      end else begin
         meas_valid <= 1'b0;
         meas_none  <= 1'b0;
         if (rise) begin
            gap <= '0;
            if (!armed) begin
               armed <= 1'b1;
               cnt   <= '0;
               edges <= '0;
            end else if (edges == EDGE_W'(N_EDGES - 1)) begin
               // window closes on this edge, which also opens the next one
               meas_valid <= 1'b1;
               meas_cnt   <= cnt + CNT_W'(1);
               cnt        <= '0;
               edges      <= '0;
            end else begin
               edges <= edges + EDGE_W'(1);
               cnt   <= cnt + CNT_W'(1);
            end
         end else if (armed) begin
            cnt <= cnt + CNT_W'(1);
            if (gap == GAP_W'(TIMEOUT_CYC - 1)) begin
               meas_none <= 1'b1;
               armed     <= 1'b0;
               gap       <= '0;
            end else begin
               gap <= gap + GAP_W'(1);
            end
         end
      end
   end

   // The gap timer must bound the window count below its register range.
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cnt < CNT_W'(CNT_MAX)));
   assert_window_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(meas_valid && meas_none));
endmodule

// File: rtl/cptd_lookup.sv
module cptd_lookup
   import cptd_pkg::*;
#(
   parameter int CLK_HZ  = 3579545,
   parameter int N_EDGES = 8,
   parameter int CNT_W   = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_valid,
   input  logic [CNT_W-1:0] meas_cnt,
   input  logic             meas_none,
   output code_t            raw_code
);
   localparam longint SPAN = longint'(CLK_HZ) * longint'(N_EDGES);

   logic [NUM_BANDS-1:0] hit;
   code_t                sel;

   generate
      for (genvar gb = 0; gb < NUM_BANDS; gb++) begin : g_band
         localparam longint LO_HZ = longint'(band_lo_hz(gb));
         localparam longint HI_HZ = longint'(band_hi_hz(gb));
         // higher frequency edge gives the smaller cycle count
         localparam logic [CNT_W-1:0] MIN_C = CNT_W'((SPAN + HI_HZ - 1) / HI_HZ);
         localparam logic [CNT_W-1:0] MAX_C = CNT_W'(SPAN / LO_HZ);
         assign hit[gb] = (meas_cnt >= MIN_C) && (meas_cnt <= MAX_C);
      end
   endgenerate

   always_comb begin
      sel = CODE_NONE;
      for (int i = NUM_BANDS - 1; i >= 0; i--) begin
         if (hit[i]) sel = code_t'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          raw_code <= CODE_NONE;
      else if (meas_valid) raw_code <= sel;
      else if (meas_none)  raw_code <= CODE_NONE;
   end

   assert_bands_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> $onehot0(hit));
   assert_raw_not_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_code != CODE_RSVD) && (raw_code != CODE_BOOT));
endmodule

// File: rtl/cptd_qualify.sv
module cptd_qualify
   import cptd_pkg::*;
#(
   parameter int MS_CYC     = 3579,
   parameter int ONSET_MS   = 24,
   parameter int LOSS_MS    = 30,
   parameter int STARTUP_MS = 30
) (
   input  logic  clk,
   input  logic  rst_n,
   input  code_t raw_code,
   output code_t code_q,
   output logic  valid_q
);
   localparam int AGE_MAX = (ONSET_MS > LOSS_MS) ? ONSET_MS : LOSS_MS;
   localparam int AGE_W   = $clog2(AGE_MAX + 1);
   localparam int PRE_W   = $clog2(MS_CYC);
   localparam int BOOT_W  = $clog2(STARTUP_MS + 1);

   logic [PRE_W-1:0]  pre;
   logic              tick;
   logic              started;
   logic [BOOT_W-1:0] boot_ms;
   code_t             cand;
   logic [AGE_W-1:0]  age;
   logic [AGE_W-1:0]  need;

   assign tick = (pre == PRE_W'(MS_CYC - 1));
   assign need = (cand == CODE_NONE) ? AGE_W'(LOSS_MS) : AGE_W'(ONSET_MS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre     <= '0;
         started <= 1'b0;
         boot_ms <= '0;
      end else begin
         pre <= tick ? '0 : pre + PRE_W'(1);
         if (!started && tick) begin
            if (boot_ms == BOOT_W'(STARTUP_MS - 1)) started <= 1'b1;
            else                                    boot_ms <= boot_ms + BOOT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand <= CODE_NONE;
         age  <= '0;
      end else if (raw_code != cand) begin
         cand <= raw_code;
         age  <= '0;
      end else if (tick && age != AGE_W'(AGE_MAX)) begin
         age <= age + AGE_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= CODE_BOOT;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (started && raw_code == cand && age >= need && cand != code_q) begin
            code_q  <= cand;
            valid_q <= 1'b1;
         end
      end
   end

   assert_boot_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (!valid_q && code_q == CODE_BOOT));
   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   assert_change_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> valid_q);
   assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (code_q != CODE_RSVD && code_q != CODE_BOOT));
endmodule

// File: rtl/cpt_classifier.sv
module cpt_classifier
   import cptd_pkg::*;
#(
   parameter int CLK_HZ      = 3579545,
   parameter int N_EDGES     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_HZ  = 300,
   parameter int ONSET_MS    = 24,
   parameter int LOSS_MS     = 30,
   parameter int STARTUP_MS  = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tone_in,
   output logic [3:0] tone_code,
   output logic       result_valid
);
   localparam int MS_CYC      = CLK_HZ / 1000;
   localparam int TIMEOUT_CYC = CLK_HZ / TIMEOUT_HZ;
   localparam int CNT_W       = $clog2(N_EDGES * TIMEOUT_CYC + 1);

   initial begin
      assert (N_EDGES >= 2) else $error("N_EDGES must be at least 2");
      assert (SYNC_STAGES >= 0) else $error("SYNC_STAGES must not be negative");
      assert (TIMEOUT_HZ > 0 && TIMEOUT_HZ < band_lo_hz(0))
         else $error("timeout must exceed the slowest band period");
      assert (MS_CYC >= 2) else $error("clock too slow for millisecond prescaler");
      assert (ONSET_MS >= 1 && LOSS_MS >= 1 && STARTUP_MS >= 1)
         else $error("delays must be at least one millisecond");
   end

   logic             rise;
   logic             meas_valid;
   logic             meas_none;
   logic [CNT_W-1:0] meas_cnt;
   code_t            raw_code;
   code_t            code_q;

   cptd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk (clk),
      .rst_n (rst_n),
      .din (tone_in),
      .rise (rise)
   );

   cptd_period #(.N_EDGES(N_EDGES), .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_period (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise       (rise),
      .meas_valid (meas_valid),
      .meas_cnt   (meas_cnt),
      .meas_none  (meas_none)
   );

   cptd_lookup #(.CLK_HZ(CLK_HZ), .N_EDGES(N_EDGES), .CNT_W(CNT_W)) u_lookup (
      .clk        (clk),
      .rst_n      (rst_n),
      .meas_valid (meas_valid),
      .meas_cnt   (meas_cnt),
      .meas_none  (meas_none),
      .raw_code   (raw_code)
   );

   cptd_qualify #(.MS_CYC(MS_CYC), .ONSET_MS(ONSET_MS), .LOSS_MS(LOSS_MS),
                  .STARTUP_MS(STARTUP_MS)) u_qualify (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_code (raw_code),
      .code_q   (code_q),
      .valid_q  (result_valid)
   );

   assign tone_code = code_q;
endmodule

// File: tb/cpt_classifier_bench.sv
`timescale 1ns/100ps
module cpt_classifier_bench;
   localparam int B_CLK   = 100000;
   localparam int B_N     = 8;
   localparam int B_MS    = B_CLK / 1000;
   localparam int B_TO    = B_CLK / 300;
   localparam int ONSET   = 10;
   localparam int LOSS    = 15;
   localparam int STARTUP = 20;
   localparam int TONE_LEN = 4000;
   localparam int SIL_LEN  = 2500;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tone_in = 1'b0;
   logic [3:0] tone_code;
   logic       result_valid;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int pq_code[$];
   int pq_cyc[$];
   logic [3:0] prev_code = 4'hE;
   logic       prev_valid = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cpt_classifier #(
      .CLK_HZ(B_CLK), .N_EDGES(B_N), .SYNC_STAGES(2), .TIMEOUT_HZ(300),
      .ONSET_MS(ONSET), .LOSS_MS(LOSS), .STARTUP_MS(STARTUP)
   ) u_cpt_classifier (
      .clk (clk),
      .rst_n (rst_n),
      .tone_in (tone_in),
      .tone_code (tone_code),
      .result_valid (result_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Per-clock model: code holds unless strobed, strobe lasts one cycle (R7).
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_code  = 4'hE;
         prev_valid = 1'b0;
      end else begin
         check((tone_code == prev_code || result_valid) && !(result_valid && prev_valid),
               "R7", "code hold / single strobe", int'(tone_code), int'(prev_code));
         if (result_valid) begin
            pq_code.push_back(int'(tone_code));
            pq_cyc.push_back(cyc);
         end
         prev_code  = tone_code;
         prev_valid = result_valid;
      end
   end

   task automatic play(input int f, input int ncyc);
      int acc = 0;
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         if (f > 0) begin
            acc += 2 * f;
            if (acc >= B_CLK) begin
               acc -= B_CLK;
               tone_in = ~tone_in;
            end
         end
      end
   endtask

   task automatic clear_q();
      pq_code.delete();
      pq_cyc.delete();
   endtask

   task automatic expect_one(input int code, input int lo, input int hi, input string req);
      check(pq_code.size() == 1, req, "strobe count", pq_code.size(), 1);
      if (pq_code.size() >= 1) begin
         check(pq_code[0] == code, req, "code", pq_code[0], code);
         check(pq_cyc[0] >= lo && pq_cyc[0] <= hi, req, "strobe cycle (lo bound)", pq_cyc[0], lo);
         check(pq_cyc[0] <= hi, req, "strobe cycle (hi bound)", pq_cyc[0], hi);
      end
   endtask

   task automatic expect_none(input string req);
      check(pq_code.size() == 0, req, "strobe count", pq_code.size(), 0);
      check(tone_code == 4'hF, req, "code", int'(tone_code), 15);
   endtask

   // R3 mapping, R5 onset window, R6 loss window
   task automatic run_tone(input int f, input int code);
      real p;
      int t0;
      int t1;
      p = real'(B_CLK) / real'(f);
      clear_q();
      t0 = cyc;
      play(f, TONE_LEN);
      t1 = cyc;
      expect_one(code, t0 + int'(B_N * p) - 5 + (ONSET - 1) * B_MS,
                 t0 + int'((B_N + 1) * p) + ONSET * B_MS + 10, "R3 R5");
      clear_q();
      play(0, SIL_LEN);
      expect_one(15, t1 - int'(p) + B_TO + (LOSS - 1) * B_MS - 5,
                 t1 + B_TO + LOSS * B_MS + 10, "R6");
   endtask

   initial begin
      int rel;
      repeat (5) @(negedge clk);
      check(tone_code == 4'hE, "R1", "code in reset", int'(tone_code), 14);
      check(result_valid == 1'b0, "R1", "strobe in reset", int'(result_valid), 0);
      rst_n = 1'b1;
      rel = cyc;
      clear_q();
      play(0, 1500);
      check(tone_code == 4'hE, "R1", "code during start-up", int'(tone_code), 14);
      check(pq_code.size() == 0, "R1", "strobes during start-up", pq_code.size(), 0);
      play(0, 1000);
      expect_one(15, rel + (STARTUP - 1) * B_MS, rel + STARTUP * B_MS + 10, "R2");

      run_tone(375, 0);
      run_tone(600, 7);
      run_tone(950, 8);
      run_tone(1300, 9);
      run_tone(1400, 10);
      run_tone(1800, 11);
      run_tone(2100, 12);

      // R4: gap between bands 0x9 and 0xA gives no report
      clear_q();
      play(1330, TONE_LEN);
      expect_none("R4");
      play(0, SIL_LEN);
      expect_none("R4");

      // R8: burst shorter than its qualification time
      clear_q();
      play(500, 2000);
      play(0, SIL_LEN);
      expect_none("R8");

      run_tone(425, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule